// File: doc/BRIEF.md
# Serial Register-Bus Slave

This block is the register-access front end of a larger device. A host frames each transaction with an active-low chip select. It first shifts in one address byte on a serial clock. It then either shifts in data bytes, which are written to a register that can only be written, or shifts out a register that can only be read. Every register has a fixed direction and a fixed width of 8 or 16 bits, and both come from its address. One address carries no data: it is a command that clears the control and mode registers. The block reports that command with a pulse, so that the status logic elsewhere in the device can clear its own flags.

The serial pins are asynchronous to the system clock. They are synchronised and edge-detected in the system clock domain, which must run at least eight times faster than the serial clock. The serial clock idles high. Command data is captured on its rising edge, and reply data changes after its falling edge, so reply data is stable whenever the serial clock is high. Register contents are presented on parallel outputs, together with a one-cycle strobe for each completed write and for each fetched read word.

Top module: `sbus_slave`

## Requirements
- R1: After reset, every register output is 0, reply_o is 0, and all strobes and gen_reset_o are 0.
- R2: Bits are captured on the rising serial clock edge, most significant bit first. The address byte comes first. Address 0xE0 (control), 0xE1 (transmit mode), 0xE2 (receive mode) and 0xE8 (program) take 16-bit words with the high byte first. Address 0xE3 (transmit data) takes 8-bit words.
- R3: A register changes only when all bytes of a word have been received. A 16-bit register that receives one byte before chip select rises keeps its old value.
- R4: If chip select rises part-way through a byte, that transaction ends with no register update and no strobe for the partial byte.
- R5: Further data bytes in the same frame form further words, and each complete word updates the register again.
- R6: Each completed write word raises one bit of wr_stb_o for one clock cycle. Bit 0 is control, 1 is transmit mode, 2 is receive mode, 3 is transmit data and 4 is program.
- R7: Address 0xE5 returns rx_data_i as 8-bit words. Address 0xE6 returns status_i as 16-bit words, high byte first. Reply bits change only after a falling serial clock edge. Every new word in the frame re-samples the input.
- R8: Each fetched read word raises rd_stb_o for one cycle at its first falling edge. Bit 0 is receive data and bit 1 is status. No strobe occurs if the frame ends before the word's first bit is clocked.
- R9: Address 0x01 clears control, transmit mode and receive mode, leaves transmit data and program unchanged, and pulses gen_reset_o once. Any data bytes that follow in that frame are ignored.
- R10: Any other address, including the reserved test addresses 0xE9 to 0xEB, changes no register, raises no strobe and returns reply 0.
- R11: reply_o is 0 while chip select is high and while the address byte is being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, idles high |
| csn_i | input | 1 | Active-low chip select |
| cmd_i | input | 1 | Serial command data from the host |
| reply_o | output | 1 | Serial reply data to the host |
| rx_data_i | input | 8 | Value returned for the receive data register |
| status_i | input | 16 | Value returned for the status register |
| gctrl_o | output | 16 | Control register |
| txmode_o | output | 16 | Transmit mode register |
| rxmode_o | output | 16 | Receive mode register |
| txdata_o | output | 8 | Transmit data register |
| prog_o | output | 16 | Program register |
| wr_stb_o | output | 5 | One-hot write strobes |
| rd_stb_o | output | 2 | One-hot read fetch strobes |
| gen_reset_o | output | 1 | Pulse for the general reset command |

## Verification
The hardest case to reach is a frame that ends at an awkward point. Examples are chip select rising after the high byte of a 16-bit word, part-way through an address byte, or after the last read word but before the next word's first falling edge. Only in these cases do the strobe counts and the register contents show whether assembly and fetch are tied to word boundaries. The stimulus varies the number of bits clocked in each frame, not only the number of whole bytes, so that frames end at every bit position in both the address and the data phase. Directed frames pin down the single-byte abort of a 16-bit write and the read frame with no data bits.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned N_WR   = 5;
  localparam int unsigned N_RD   = 2;
  localparam int unsigned WIDX_W = $clog2(N_WR);

  typedef enum logic [3:0] {
    REG_NONE, REG_RESET, REG_GCTRL, REG_TXMODE, REG_RXMODE,
    REG_TXDATA, REG_RXDATA, REG_STATUS, REG_PROG
  } reg_id_e;

  typedef struct packed {
    reg_id_e           id;
    logic              rd;
    logic              wr;
    logic              wide;
    logic [WIDX_W-1:0] wr_idx;
    logic              rd_idx;
  } reg_dec_t;

  function automatic reg_dec_t decode_addr(input logic [BYTE_W-1:0] a);
    reg_dec_t d;
    d = '{id: REG_NONE, rd: 1'b0, wr: 1'b0, wide: 1'b0, wr_idx: '0, rd_idx: 1'b0};
    case (a)
      8'h01: d.id = REG_RESET;
      8'hE0: begin d.id = REG_GCTRL;  d.wr = 1'b1; d.wide = 1'b1; d.wr_idx = WIDX_W'(0); end
      8'hE1: begin d.id = REG_TXMODE; d.wr = 1'b1; d.wide = 1'b1; d.wr_idx = WIDX_W'(1); end
      8'hE2: begin d.id = REG_RXMODE; d.wr = 1'b1; d.wide = 1'b1; d.wr_idx = WIDX_W'(2); end
      8'hE3: begin d.id = REG_TXDATA; d.wr = 1'b1; d.wide = 1'b0; d.wr_idx = WIDX_W'(3); end
      8'hE5: begin d.id = REG_RXDATA; d.rd = 1'b1; d.wide = 1'b0; d.rd_idx = 1'b0; end
      8'hE6: begin d.id = REG_STATUS; d.rd = 1'b1; d.wide = 1'b1; d.rd_idx = 1'b1; end
      8'hE8: begin d.id = REG_PROG;   d.wr = 1'b1; d.wide = 1'b1; d.wr_idx = WIDX_W'(4); end
      default: ;
    endcase
    return d;
  endfunction

  // width of write slot i
  function automatic int unsigned wr_width(input int unsigned i);
    return (i == 3) ? BYTE_W : WORD_W;
  endfunction

  // slots cleared by the general reset command
  function automatic bit wr_clearable(input int unsigned i);
    return i < 3;
  endfunction
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] stg_q [STAGES];
  logic [N-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= stg_q[STAGES-1];

  assign q_o    = stg_q[STAGES-1];
  assign rise_o = q_o & ~prev_q;
  assign fall_o = ~q_o & prev_q;
endmodule

// File: rtl/sbus_frame.sv
module sbus_frame
  import sbus_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned WW = WORD_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_idle_i,
  input  logic                    rise_i,
  input  logic                    din_i,
  output reg_dec_t                dec_o,
  output logic                    in_data_o,
  output logic [$clog2(WW)-1:0]   cnt_o,
  output logic [WW-1:0]           word_o,
  output logic                    word_vld_o,
  output logic                    greset_o
);
  localparam int unsigned CW = $clog2(WW);

  logic [WW-2:0] sh_q;
  logic [WW-1:0] nxt;
  logic [CW-1:0] cnt_q, last;
  logic          in_data_q, word_vld_q, greset_q;
  logic [WW-1:0] word_q;
  reg_dec_t      dec_q, addr_dec;

  assign nxt      = {sh_q, din_i};
  assign addr_dec = decode_addr(nxt[BW-1:0]);
  assign last     = dec_q.wide ? CW'(WW-1) : CW'(BW-1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      in_data_q  <= 1'b0;
      word_vld_q <= 1'b0;
      greset_q   <= 1'b0;
      word_q     <= '0;
      dec_q      <= '0;
    end else begin
      word_vld_q <= 1'b0;
      greset_q   <= 1'b0;
      if (cs_idle_i) begin
        in_data_q <= 1'b0;
        cnt_q     <= '0;
      end else if (rise_i) begin
        sh_q <= nxt[WW-2:0];
        if (!in_data_q) begin
          if (cnt_q == CW'(BW-1)) begin
            dec_q     <= addr_dec;
            in_data_q <= 1'b1;
            cnt_q     <= '0;
            greset_q  <= (addr_dec.id == REG_RESET);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (cnt_q == last) begin
          cnt_q      <= '0;
          word_vld_q <= dec_q.wr;
          word_q     <= dec_q.wide ? nxt : {{(WW-BW){1'b0}}, nxt[BW-1:0]};
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign dec_o      = dec_q;
  assign in_data_o  = in_data_q;
  assign cnt_o      = cnt_q;
  assign word_o     = word_q;
  assign word_vld_o = word_vld_q;
  assign greset_o   = greset_q;
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile
  import sbus_pkg::*;
#(
  parameter int unsigned WW = WORD_W,
  parameter int unsigned NW = N_WR
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     word_vld_i,
  input  logic [WIDX_W-1:0]        wr_idx_i,
  input  logic [WW-1:0]            word_i,
  input  logic                     greset_i,
  output logic [NW-1:0][WW-1:0]    regs_o,
  output logic [NW-1:0]            wr_stb_o,
  output logic                     gen_reset_o
);
  for (genvar i = 0; i < NW; i++) begin : g_reg
    localparam int unsigned W = wr_width(i);
    logic [W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                   r_q <= '0;
      else if (greset_i && wr_clearable(i))          r_q <= '0;
      else if (word_vld_i && wr_idx_i == WIDX_W'(i)) r_q <= word_i[W-1:0];
    if (W < WW) begin : g_pad
      assign regs_o[i] = {{(WW-W){1'b0}}, r_q};
    end else begin : g_full
      assign regs_o[i] = r_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wr_stb_o    <= '0;
      gen_reset_o <= 1'b0;
    end else begin
      wr_stb_o    <= word_vld_i ? (NW'(1) << wr_idx_i) : '0;
      gen_reset_o <= greset_i;
    end
endmodule

// File: rtl/sbus_reply.sv
module sbus_reply
  import sbus_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned WW = WORD_W,
  parameter int unsigned NR = N_RD
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_idle_i,
  input  logic                   fall_i,
  input  logic                   in_data_i,
  input  logic [$clog2(WW)-1:0]  cnt_i,
  input  logic                   rd_i,
  input  logic                   rd_idx_i,
  input  logic [BW-1:0]          rx_data_i,
  input  logic [WW-1:0]          status_i,
  output logic                   reply_o,
  output logic [NR-1:0]          rd_stb_o
);
  logic [WW-2:0] sh_q;
  logic [WW-1:0] fetch;
  logic          reply_q;
  logic [NR-1:0] rd_stb_q;

  // narrow registers are left-aligned so the MSB goes out first
  assign fetch = rd_idx_i ? status_i : {rx_data_i, {(WW-BW){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      reply_q  <= 1'b0;
      rd_stb_q <= '0;
    end else begin
      rd_stb_q <= '0;
      if (cs_idle_i) begin
        reply_q <= 1'b0;
      end else if (fall_i) begin
        if (in_data_i && rd_i) begin
          if (cnt_i == '0) begin
            reply_q  <= fetch[WW-1];
            sh_q     <= fetch[WW-2:0];
            rd_stb_q <= NR'(1) << rd_idx_i;
          end else begin
            reply_q <= sh_q[WW-2];
            sh_q    <= {sh_q[WW-3:0], 1'b0};
          end
        end else begin
          reply_q <= 1'b0;
        end
      end
    end
  end

  assign reply_o  = reply_q;
  assign rd_stb_o = rd_stb_q;
endmodule

// File: rtl/sbus_slave.sv
module sbus_slave
  import sbus_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 csn_i,
  input  logic                 cmd_i,
  output logic                 reply_o,
  input  logic [BYTE_W-1:0]    rx_data_i,
  input  logic [WORD_W-1:0]    status_i,
  output logic [WORD_W-1:0]    gctrl_o,
  output logic [WORD_W-1:0]    txmode_o,
  output logic [WORD_W-1:0]    rxmode_o,
  output logic [BYTE_W-1:0]    txdata_o,
  output logic [WORD_W-1:0]    prog_o,
  output logic [N_WR-1:0]      wr_stb_o,
  output logic [N_RD-1:0]      rd_stb_o,
  output logic                 gen_reset_o
);
  localparam int unsigned CW = $clog2(WORD_W);

  logic [2:0] pin_q, pin_rise, pin_fall;
  logic       cs_idle, sclk_rise, sclk_fall, din;

  // bit 0 csn, bit 1 sclk, bit 2 cmd
  sbus_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk_i, .rst_ni,
    .d_i    ({cmd_i, sclk_i, csn_i}),
    .q_o    (pin_q),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign cs_idle   = pin_q[0];
  assign din       = pin_q[2];
  assign sclk_rise = pin_rise[1] & ~cs_idle;
  assign sclk_fall = pin_fall[1] & ~cs_idle;

  reg_dec_t            dec;
  logic                in_data, word_vld, greset;
  logic [CW-1:0]       cnt;
  logic [WORD_W-1:0]   word;
  logic [N_WR-1:0][WORD_W-1:0] regs;

  sbus_frame u_frame (
    .clk_i, .rst_ni,
    .cs_idle_i  (cs_idle),
    .rise_i     (sclk_rise),
    .din_i      (din),
    .dec_o      (dec),
    .in_data_o  (in_data),
    .cnt_o      (cnt),
    .word_o     (word),
    .word_vld_o (word_vld),
    .greset_o   (greset)
  );

  sbus_regfile u_regs (
    .clk_i, .rst_ni,
    .word_vld_i  (word_vld),
    .wr_idx_i    (dec.wr_idx),
    .word_i      (word),
    .greset_i    (greset),
    .regs_o      (regs),
    .wr_stb_o    (wr_stb_o),
    .gen_reset_o (gen_reset_o)
  );

  sbus_reply u_reply (
    .clk_i, .rst_ni,
    .cs_idle_i (cs_idle),
    .fall_i    (sclk_fall),
    .in_data_i (in_data),
    .cnt_i     (cnt),
    .rd_i      (dec.rd),
    .rd_idx_i  (dec.rd_idx),
    .rx_data_i (rx_data_i),
    .status_i  (status_i),
    .reply_o   (reply_o),
    .rd_stb_o  (rd_stb_o)
  );

  assign gctrl_o  = regs[0];
  assign txmode_o = regs[1];
  assign rxmode_o = regs[2];
  assign txdata_o = regs[3][BYTE_W-1:0];
  assign prog_o   = regs[4];

  logic unused_bits;
  assign unused_bits = ^{pin_rise[0], pin_rise[2], pin_fall[0], pin_fall[2], pin_q[1],
                         dec.id, dec.wr, dec.wide, regs[3][WORD_W-1:BYTE_W]};
endmodule

// File: rtl/sbus_slave_chk.sv
module sbus_slave_chk
  import sbus_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reply_o,
  input logic [WORD_W-1:0] gctrl_o,
  input logic [WORD_W-1:0] txmode_o,
  input logic [WORD_W-1:0] rxmode_o,
  input logic [BYTE_W-1:0] txdata_o,
  input logic [N_WR-1:0]   wr_stb_o,
  input logic [N_RD-1:0]   rd_stb_o,
  input logic              gen_reset_o,
  input logic              cs_idle,
  input logic              sclk_fall
);
  p_wr_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_stb_o));
  p_wr_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_stb_o) |=> !(|wr_stb_o));
  p_rd_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_stb_o));
  p_rd_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rd_stb_o) |=> !(|rd_stb_o));
  p_greset_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_reset_o |-> (gctrl_o == '0 && txmode_o == '0 && rxmode_o == '0));
  p_greset_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_reset_o |=> !gen_reset_o);
  p_reply_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_idle) |-> !reply_o);
  p_reply_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(reply_o) |-> $past(sclk_fall || cs_idle));
  p_gctrl_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gctrl_o) |-> (wr_stb_o[0] || gen_reset_o));
  p_txdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txdata_o) |-> wr_stb_o[3]);
endmodule

bind sbus_slave sbus_slave_chk u_chk (.*);

// File: tb/sim_sbus_slave.sv
module sim_sbus_slave;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, csn = 1'b1, cmd = 1'b0;
  logic [7:0]  rxd = '0;
  logic [15:0] stat = '0;
  logic        reply, greset;
  logic [15:0] gctrl, txmode, rxmode, prog;
  logic [7:0]  txdata;
  logic [4:0]  wr_stb;
  logic [1:0]  rd_stb;

  always #4 clk = ~clk;

  sbus_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .cmd_i(cmd),
    .reply_o(reply), .rx_data_i(rxd), .status_i(stat),
    .gctrl_o(gctrl), .txmode_o(txmode), .rxmode_o(rxmode), .txdata_o(txdata),
    .prog_o(prog), .wr_stb_o(wr_stb), .rd_stb_o(rd_stb), .gen_reset_o(greset)
  );

  int n_chk = 0, n_fail = 0;
  int wr_cnt [5];
  int rd_cnt [2];
  int gr_cnt;
  int exp_wr [5];
  int exp_rd [2];
  int exp_gr;
  logic [15:0] exp_reg [5];
  logic [7:0]  dby [8];

  always @(posedge clk) if (rst_n) begin
    for (int i = 0; i < 5; i++) if (wr_stb[i]) wr_cnt[i]++;
    for (int i = 0; i < 2; i++) if (rd_stb[i]) rd_cnt[i]++;
    if (greset) gr_cnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] reg_out(input int i);
    case (i)
      0: return gctrl;
      1: return txmode;
      2: return rxmode;
      3: return {8'h00, txdata};
      default: return prog;
    endcase
  endfunction

  // write slot for an address, -1 if not writable
  function automatic int wslot(input logic [7:0] a);
    case (a)
      8'hE0: return 0;
      8'hE1: return 1;
      8'hE2: return 2;
      8'hE3: return 3;
      8'hE8: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic run_frame(input string tag, input logic [7:0] addr, input int nbits);
    logic rep [80];
    int db, s, wb, words, mism;
    logic [15:0] rv;
    int rbits;
    for (int i = 0; i < 5; i++) begin wr_cnt[i] = 0; exp_wr[i] = 0; end
    for (int i = 0; i < 2; i++) begin rd_cnt[i] = 0; exp_rd[i] = 0; end
    gr_cnt = 0; exp_gr = 0;
    csn = 1'b0;
    tick(4);
    for (int b = 0; b < nbits; b++) begin
      sclk = 1'b0;
      cmd  = (b < 8) ? addr[7-b] : dby[(b-8)/8][7-((b-8)%8)];
      tick(H);
      sclk = 1'b1;
      tick(H/2);
      rep[b] = reply;
      tick(H - H/2);
    end
    tick(2);
    csn = 1'b1;
    tick(10);

    // expected model
    db = nbits - 8;
    s = wslot(addr);
    rbits = 0;
    rv = '0;
    if (nbits >= 8) begin
      if (s >= 0) begin
        wb = (s == 3) ? 1 : 2;
        words = (db / 8) / wb;
        if (words > 0) begin
          exp_reg[s] = (wb == 2) ? {dby[2*words-2], dby[2*words-1]} : {8'h00, dby[words-1]};
          exp_wr[s] = words;
        end
      end else if (addr == 8'h01) begin
        exp_reg[0] = '0; exp_reg[1] = '0; exp_reg[2] = '0;
        exp_gr = 1;
      end else if (addr == 8'hE5) begin
        rbits = 8; rv = {rxd, 8'h00};
        exp_rd[0] = (db + 7) / 8;
      end else if (addr == 8'hE6) begin
        rbits = 16; rv = stat;
        exp_rd[1] = (db + 15) / 16;
      end
    end

    mism = 0;
    for (int b = 0; b < nbits; b++) begin
      logic e;
      e = (b >= 8 && rbits > 0) ? rv[15 - ((b-8) % rbits)] : 1'b0;
      if (rep[b] !== e) mism++;
    end
    chk($sformatf("%s R7/R10/R11 reply bit mismatches addr=%0h", tag, addr), mism, 0);
    for (int i = 0; i < 5; i++)
      chk($sformatf("%s R2/R3 register %0d addr=%0h", tag, i, addr), reg_out(i), exp_reg[i]);
    chk($sformatf("%s R6 write strobe counts", tag),
        {wr_cnt[4][3:0], wr_cnt[3][3:0], wr_cnt[2][3:0], wr_cnt[1][3:0], wr_cnt[0][3:0]},
        {exp_wr[4][3:0], exp_wr[3][3:0], exp_wr[2][3:0], exp_wr[1][3:0], exp_wr[0][3:0]});
    chk($sformatf("%s R8 read strobe counts", tag),
        {rd_cnt[1][7:0], rd_cnt[0][7:0]}, {exp_rd[1][7:0], exp_rd[0][7:0]});
    chk($sformatf("%s R9 general reset pulses", tag), gr_cnt, exp_gr);
    chk($sformatf("%s R11 reply idle", tag), reply, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] amap [12];
    void'($urandom(32'h1D2C_3B4A));
    for (int i = 0; i < 5; i++) exp_reg[i] = '0;
    tick(3);
    // R1 reset state
    for (int i = 0; i < 5; i++) chk($sformatf("R1 reset register %0d", i), reg_out(i), 16'h0);
    chk("R1 reset reply", reply, 1'b0);
    chk("R1 reset strobes", {wr_stb, rd_stb, greset}, 8'h00);
    rst_n = 1'b1;
    tick(4);

    dby[0] = 8'hA5; dby[1] = 8'h5A;
    run_frame("R2 wide write", 8'hE0, 24);
    dby[0] = 8'h3C;
    run_frame("R3 lone high byte", 8'hE1, 16);
    dby[0] = 8'h12; dby[1] = 8'h34; dby[2] = 8'h56;
    run_frame("R4 abort mid byte", 8'hE1, 8 + 16 + 5);
    run_frame("R4 abort in address", 8'hE2, 5);
    dby[0] = 8'h11; dby[1] = 8'h22; dby[2] = 8'h33;
    run_frame("R5 repeated byte writes", 8'hE3, 32);
    dby[0] = 8'hC3; dby[1] = 8'h96;
    run_frame("R2 program write", 8'hE8, 24);
    stat = 16'hB2E4;
    run_frame("R7 status two words", 8'hE6, 40);
    rxd = 8'h9D;
    run_frame("R8 read without data bits", 8'hE5, 8);
    run_frame("R7 receive data partial", 8'hE5, 11);
    dby[0] = 8'hFF; dby[1] = 8'hFF;
    run_frame("R9 reset with trailing bytes", 8'h01, 24);
    dby[0] = 8'h77; dby[1] = 8'h88;
    run_frame("R10 reserved address", 8'hEA, 24);
    run_frame("R10 unmapped address", 8'h42, 24);

    amap = '{8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE5, 8'hE6, 8'hE8, 8'h01, 8'hE9, 8'hEB, 8'hE4, 8'h00};
    for (int it = 0; it < 60; it++) begin
      logic [7:0] a;
      int nb, nbits;
      a = amap[$urandom_range(0, 11)];
      nb = $urandom_range(0, 4);
      nbits = 8 + 8 * nb;
      if ($urandom_range(0, 3) == 0) nbits += $urandom_range(1, 7);
      if ($urandom_range(0, 9) == 0) nbits = $urandom_range(1, 7);
      for (int i = 0; i < 8; i++) dby[i] = 8'($urandom());
      rxd  = 8'($urandom());
      stat = 16'($urandom());
      run_frame("random", a, nbits);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule